// File: doc/BRIEF.md
# Gapped 16-to-32-bit DMA Packer

This block sits between a network controller's 16-bit DMA master and a 32-bit shared memory. The controller believes it owns a flat, word-addressed region of 64 KB. Each controller access is translated into an access on a 32-bit memory port. Two layouts are supported, and the controller picks one for each access.

In buffer mode, packet data is stored as sixteen valid bytes followed by sixteen unused bytes. Consecutive 16-bit words are packed in pairs into 32-bit memory words, so a burst of eight controller words becomes four memory words. In structure mode, each 16-bit word uses the low half of its own 32-bit memory word. This mode serves the descriptor and initialisation area.

A base register places the region in physical memory. System logic provides a DMA enable that gates all traffic. Any access that translates beyond the 128 KB window is refused and flagged with a memory-error pulse. Both sides use a request/acknowledge handshake: a requester holds its request until it sees one acknowledge.

Top module: `gapped_dma_packer`

## Requirements
- R1: The memory byte address equals (base register value shifted right by 3) plus the translated offset. The address is always 32-bit aligned. The base register loads `cfg_base_val` when `cfg_base_wr` is high.
- R2: In buffer mode (`ctl_burst`=1), controller word address w gives byte offset b=2w. This maps to the translated offset ((b & ~0xF) << 1) | (b & 0xF). Words with w[0]=1 use byte lanes 3:2, and words with w[0]=0 use byte lanes 1:0.
- R3: In structure mode (`ctl_burst`=0), word w maps to translated offset 4w. A write uses byte enables 0011 with upper data bits zero. A read returns bits 15:0 of the memory word.
- R4: A buffer-mode write of an even word with `ctl_last`=0 is held and acknowledged without a memory access. The following write to the odd partner word issues one write with byte enables 1111 and data {odd, even}.
- R5: A buffer-mode odd-word write with no held partner writes with byte enables 1100, with bits 15:0 zero. An even-word write with `ctl_last`=1 writes at once with byte enables 0011.
- R6: A held word is written out first, with byte enables 0011, when any accepted access other than its partner write arrives. Only after that write is the new access served.
- R7: A buffer-mode read that misses fetches the whole memory word (byte enables 1111) and returns the addressed half. A following buffer-mode read of either half of the same memory word is answered from the stored word without a memory access. Any accepted write, and any base register load, discards the stored word.
- R8: An access whose translated offset is 128 KB or more is acknowledged with `merr_irq` high for that cycle and `ctl_rdata` zero. No memory access is made.
- R9: While `dma_en` is low, no new controller request is accepted and no new memory request starts. A pending request is served once `dma_en` returns high.
- R10: `ctl_ack` is high for exactly one cycle per access. `mem_req` and all memory request fields stay stable until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_en | input | 1 | System DMA enable; gates all transfers |
| cfg_base_wr | input | 1 | Load strobe for the base register |
| cfg_base_val | input | ADDR_W+3 | Base register value (physical start shifted left by 3) |
| ctl_req | input | 1 | Controller access request, held until acknowledged |
| ctl_we | input | 1 | Controller write (1) or read (0) |
| ctl_burst | input | 1 | Buffer mode (1) or structure mode (0) |
| ctl_last | input | 1 | Marks the final word of a buffer-mode write burst |
| ctl_addr | input | CTL_AW | Controller 16-bit word address |
| ctl_wdata | input | 16 | Controller write data |
| ctl_ack | output | 1 | One-cycle access acknowledge |
| ctl_rdata | output | 16 | Read data, valid with `ctl_ack` |
| merr_irq | output | 1 | Memory-error pulse for a refused access |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | ADDR_W | Memory byte address, 32-bit aligned |
| mem_be | output | 4 | Memory byte enables |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge; read data valid with it |
| mem_rdata | input | 32 | Memory read data |

## Verification
A fault in the packing state shows up at the memory port on the next memory request. Wrong byte enables, a missing or merged word, or a stale half can each appear there. The bench checks every memory transaction against an expected list and compares the count of transactions.

A stored read word that is not discarded after a write would return stale data on the very next partner read. The refetch test after a write exposes this within one access. An address translation fault appears on the first memory request after the access is accepted. A missing error gate appears as an unexpected memory transaction in place of the `merr_irq` pulse on the acknowledge cycle.

// File: rtl/dmap_pkg.sv
package dmap_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_MEM  = 1'b1
    } dmap_st_e;

    localparam logic [3:0] BE_LOW  = 4'b0011;
    localparam logic [3:0] BE_HIGH = 4'b1100;
    localparam logic [3:0] BE_ALL  = 4'b1111;

endpackage

// File: rtl/dmap_xlate.sv
module dmap_xlate #(
    parameter int CTL_AW = 16,
    parameter int ADDR_W = 32,
    parameter int WIN_AW = 17
) (
    input  logic [CTL_AW-1:0] word,
    input  logic              burst,
    input  logic [ADDR_W+2:0] base,
    output logic [ADDR_W-3:0] lw,
    output logic              hi,
    output logic              oow
);
    localparam int OFF_W = CTL_AW + 2;

    logic [CTL_AW:0]   boff;
    logic [OFF_W-1:0]  off;
    logic [ADDR_W-1:0] sum;

    always_comb begin
        boff = {word, 1'b0};
        // buffer layout: every 16-byte block is spread over 32 bytes
        off  = burst ? {boff[CTL_AW:4], 1'b0, boff[3:0]} : {word, 2'b00};
        sum  = ADDR_W'(base >> 3) + ADDR_W'(off);
        lw   = (ADDR_W-2)'(sum >> 2);
        hi   = burst & word[0];
    end

    generate
        if (WIN_AW >= OFF_W) begin : g_no_limit
            assign oow = 1'b0;
        end else begin : g_limit
            assign oow = |off[OFF_W-1:WIN_AW];
        end
    endgenerate

endmodule

// File: rtl/dmap_slot.sv
module dmap_slot #(
    parameter int TAG_W  = 30,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              clear,
    input  logic [TAG_W-1:0]  tag_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              valid,
    output logic [TAG_W-1:0]  tag,
    output logic [DATA_W-1:0] data
);
    typedef struct packed {
        logic              vld;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } slot_t;

    slot_t d, q;

    always_comb begin
        d = q;
        if (clear) begin
            d.vld = 1'b0;
        end else if (load) begin
            d.vld  = 1'b1;
            d.tag  = tag_in;
            d.data = data_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign valid = q.vld;
    assign tag   = q.tag;
    assign data  = q.data;

endmodule

// File: rtl/gapped_dma_packer.sv
module gapped_dma_packer
    import dmap_pkg::*;
#(
    parameter int CTL_AW = 16,
    parameter int ADDR_W = 32,
    parameter int WIN_AW = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dma_en,
    input  logic              cfg_base_wr,
    input  logic [ADDR_W+2:0] cfg_base_val,
    input  logic              ctl_req,
    input  logic              ctl_we,
    input  logic              ctl_burst,
    input  logic              ctl_last,
    input  logic [CTL_AW-1:0] ctl_addr,
    input  logic [15:0]       ctl_wdata,
    output logic              ctl_ack,
    output logic [15:0]       ctl_rdata,
    output logic              merr_irq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata
);
    localparam int BASE_W = ADDR_W + 3;
    localparam int LW_W   = ADDR_W - 2;

    typedef struct packed {
        dmap_st_e          st;
        logic              ack;
        logic [15:0]       rdata;
        logic              merr;
        logic              mreq;
        logic              mwe;
        logic [ADDR_W-1:0] maddr;
        logic [3:0]        mbe;
        logic [31:0]       mwd;
        logic [BASE_W-1:0] base;
        logic              p_flush;
        logic              p_rd;
        logic              p_fill;
        logic              p_hi;
    } regs_t;

    regs_t d, q;

    logic [LW_W-1:0] xl_lw;
    logic            xl_hi;
    logic            xl_oow;

    logic            hold_ld, hold_clr, h_vld;
    logic [LW_W-1:0] h_tag;
    logic [15:0]     h_data;

    logic            c_fill, c_inval, c_vld;
    logic [LW_W-1:0] c_tag;
    logic [31:0]     c_data;

    dmap_xlate #(.CTL_AW(CTL_AW), .ADDR_W(ADDR_W), .WIN_AW(WIN_AW)) u_xlate (
        .word  (ctl_addr),
        .burst (ctl_burst),
        .base  (q.base),
        .lw    (xl_lw),
        .hi    (xl_hi),
        .oow   (xl_oow)
    );

    // even buffer word waiting for its odd partner
    dmap_slot #(.TAG_W(LW_W), .DATA_W(16)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (hold_ld),
        .clear   (hold_clr),
        .tag_in  (xl_lw),
        .data_in (ctl_wdata),
        .valid   (h_vld),
        .tag     (h_tag),
        .data    (h_data)
    );

    // last longword fetched by a buffer read
    dmap_slot #(.TAG_W(LW_W), .DATA_W(32)) u_rbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (c_fill),
        .clear   (c_inval),
        .tag_in  (q.maddr[ADDR_W-1:2]),
        .data_in (mem_rdata),
        .valid   (c_vld),
        .tag     (c_tag),
        .data    (c_data)
    );

    always_comb begin
        d        = q;
        d.ack    = 1'b0;
        d.merr   = 1'b0;
        hold_ld  = 1'b0;
        hold_clr = 1'b0;
        c_fill   = 1'b0;
        c_inval  = 1'b0;

        if (cfg_base_wr) begin
            d.base  = cfg_base_val;
            c_inval = 1'b1;
        end

        unique case (q.st)
            ST_IDLE: begin
                if (ctl_req && dma_en && !q.ack) begin
                    if (xl_oow) begin
                        d.ack   = 1'b1;
                        d.merr  = 1'b1;
                        d.rdata = '0;
                    end else if (h_vld && !(ctl_we && ctl_burst && xl_hi && (h_tag == xl_tag_f()))) begin
                        d.mreq    = 1'b1;
                        d.mwe     = 1'b1;
                        d.maddr   = {h_tag, 2'b00};
                        d.mbe     = BE_LOW;
                        d.mwd     = {16'h0000, h_data};
                        d.p_flush = 1'b1;
                        d.p_rd    = 1'b0;
                        d.p_fill  = 1'b0;
                        hold_clr  = 1'b1;
                        d.st      = ST_MEM;
                    end else if (ctl_we) begin
                        c_inval = 1'b1;
                        if (ctl_burst && !xl_hi && !ctl_last) begin
                            hold_ld = 1'b1;
                            d.ack   = 1'b1;
                        end else begin
                            d.mreq    = 1'b1;
                            d.mwe     = 1'b1;
                            d.maddr   = {xl_lw, 2'b00};
                            d.p_flush = 1'b0;
                            d.p_rd    = 1'b0;
                            d.p_fill  = 1'b0;
                            if (xl_hi) begin
                                d.mbe    = h_vld ? BE_ALL : BE_HIGH;
                                d.mwd    = {ctl_wdata, (h_vld ? h_data : 16'h0000)};
                                hold_clr = 1'b1;
                            end else begin
                                d.mbe = BE_LOW;
                                d.mwd = {16'h0000, ctl_wdata};
                            end
                            d.st = ST_MEM;
                        end
                    end else if (ctl_burst && c_vld && (c_tag == xl_lw)) begin
                        d.ack   = 1'b1;
                        d.rdata = xl_hi ? c_data[31:16] : c_data[15:0];
                    end else begin
                        d.mreq    = 1'b1;
                        d.mwe     = 1'b0;
                        d.maddr   = {xl_lw, 2'b00};
                        d.mbe     = ctl_burst ? BE_ALL : BE_LOW;
                        d.mwd     = '0;
                        d.p_flush = 1'b0;
                        d.p_rd    = 1'b1;
                        d.p_fill  = ctl_burst;
                        d.p_hi    = xl_hi;
                        d.st      = ST_MEM;
                    end
                end
            end
            ST_MEM: begin
                if (mem_ack) begin
                    d.mreq = 1'b0;
                    d.st   = ST_IDLE;
                    if (!q.p_flush) d.ack = 1'b1;
                    if (q.p_rd) begin
                        d.rdata = q.p_hi ? mem_rdata[31:16] : mem_rdata[15:0];
                        c_fill  = q.p_fill && !cfg_base_wr;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    function automatic logic [LW_W-1:0] xl_tag_f();
        return xl_lw;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ctl_ack   = q.ack;
    assign ctl_rdata = q.rdata;
    assign merr_irq  = q.merr;
    assign mem_req   = q.mreq;
    assign mem_we    = q.mwe;
    assign mem_addr  = q.maddr;
    assign mem_be    = q.mbe;
    assign mem_wdata = q.mwd;

endmodule

// File: rtl/dmap_chk.sv
module dmap_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dma_en,
    input logic              ctl_ack,
    input logic              merr_irq,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [3:0]        mem_be,
    input logic [31:0]       mem_wdata,
    input logic              mem_ack
);
    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00)); // R1

    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_ack |=> !ctl_ack); // R10

    AST_MREQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_be)
                                   && $stable(mem_we) && $stable(mem_wdata))); // R10

    AST_GATE_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_en && !mem_req) |=> !mem_req); // R9

    AST_GATE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_en && !mem_req) |=> !ctl_ack); // R9

    AST_MERR_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        merr_irq |-> (ctl_ack && !mem_req)); // R8

    AST_READ_BE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> (mem_be == 4'b1111 || mem_be == 4'b0011)); // R7

    AST_WRITE_BE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_be == 4'b1111 || mem_be == 4'b0011 || mem_be == 4'b1100)); // R5

    AST_HIGH_ONLY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_be == 4'b1100) |-> (mem_wdata[15:0] == 16'h0000)); // R5

    AST_LOW_ONLY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_be == 4'b0011) |-> (mem_wdata[31:16] == 16'h0000)); // R3

endmodule

bind gapped_dma_packer dmap_chk #(.ADDR_W(ADDR_W)) u_dmap_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dma_en    (dma_en),
    .ctl_ack   (ctl_ack),
    .merr_irq  (merr_irq),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack)
);

// File: tb/gapped_dma_packer_bench.sv
module gapped_dma_packer_bench;
    localparam int CTL_AW = 16;
    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              dma_en = 1'b1;
    logic              cfg_base_wr = 1'b0;
    logic [ADDR_W+2:0] cfg_base_val = '0;
    logic              ctl_req = 1'b0, ctl_we = 1'b0, ctl_burst = 1'b0, ctl_last = 1'b0;
    logic [CTL_AW-1:0] ctl_addr = '0;
    logic [15:0]       ctl_wdata = '0;
    logic              ctl_ack, merr_irq;
    logic [15:0]       ctl_rdata;
    logic              mem_req, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [3:0]        mem_be;
    logic [31:0]       mem_wdata;
    logic              mem_ack = 1'b0;
    logic [31:0]       mem_rdata = '0;

    gapped_dma_packer #(.CTL_AW(CTL_AW), .ADDR_W(ADDR_W), .WIN_AW(17)) u_gapped_dma_packer (
        .clk(clk), .rst_n(rst_n), .dma_en(dma_en),
        .cfg_base_wr(cfg_base_wr), .cfg_base_val(cfg_base_val),
        .ctl_req(ctl_req), .ctl_we(ctl_we), .ctl_burst(ctl_burst), .ctl_last(ctl_last),
        .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata),
        .ctl_ack(ctl_ack), .ctl_rdata(ctl_rdata), .merr_irq(merr_irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int tx_cnt = 0;

    typedef struct {
        logic        we;
        logic [31:0] addr;
        logic [3:0]  be;
        logic [31:0] data;
        string       req;
    } exp_t;

    exp_t        exp_q[$];
    logic [31:0] mem[int];
    int          lat = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic expect_tx(input logic we, input logic [31:0] addr, input logic [3:0] be,
                             input logic [31:0] data, input string req);
        exp_t e;
        e.we = we; e.addr = addr; e.be = be; e.data = data; e.req = req;
        exp_q.push_back(e);
    endtask

    // memory model and scoreboard monitor
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (lat == 1) begin
                int key;
                logic [31:0] cur;
                lat = 0;
                tx_cnt++;
                key = int'(mem_addr >> 2);
                cur = mem.exists(key) ? mem[key] : 32'h0;
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R6 unexpected memory access: actual we=%0b addr=%h be=%b data=%h expected none",
                             mem_we, mem_addr, mem_be, mem_wdata);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (mem_we !== e.we || mem_addr !== e.addr || mem_be !== e.be ||
                        (e.we && mem_wdata !== e.data)) begin
                        errors++;
                        $display("FAIL %s memory access: actual we=%0b addr=%h be=%b data=%h expected we=%0b addr=%h be=%b data=%h",
                                 e.req, mem_we, mem_addr, mem_be, mem_wdata, e.we, e.addr, e.be, e.data);
                    end
                end
                if (mem_we) begin
                    for (int i = 0; i < 4; i++)
                        if (mem_be[i]) cur[i*8 +: 8] = mem_wdata[i*8 +: 8];
                    mem[key] = cur;
                end
                mem_rdata = cur;
                mem_ack = 1'b1;
            end else begin
                lat++;
            end
        end
    end

    task automatic access(input logic we, input logic burst, input logic last,
                          input logic [15:0] a, input logic [15:0] wd,
                          output logic [15:0] rd, output logic me);
        @(negedge clk);
        ctl_req = 1'b1; ctl_we = we; ctl_burst = burst; ctl_last = last;
        ctl_addr = a; ctl_wdata = wd;
        do @(negedge clk); while (!ctl_ack);
        rd = ctl_rdata;
        me = merr_irq;
        ctl_req = 1'b0;
        @(negedge clk);
        chk(!ctl_ack, "R10 ack lasts one cycle", {31'h0, ctl_ack}, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        logic        me;
        int          n0;

        repeat (3) @(negedge clk);
        chk(!ctl_ack && !mem_req && !merr_irq, "R10 reset state",
            {29'h0, ctl_ack, mem_req, merr_irq}, 32'h0);
        rst_n = 1'b1;

        // R1: base register holds physical start 0x40000 shifted left by 3
        @(negedge clk);
        cfg_base_wr = 1'b1; cfg_base_val = 35'h20_0000;
        @(negedge clk);
        cfg_base_wr = 1'b0;

        // R1 R3: structure write/read of word 3
        expect_tx(1'b1, 32'h0004_000C, 4'b0011, 32'h0000_BEEF, "R3 structure write");
        access(1'b1, 1'b0, 1'b0, 16'h0003, 16'hBEEF, rd, me);
        expect_tx(1'b0, 32'h0004_000C, 4'b0011, 32'h0, "R1 structure read");
        access(1'b0, 1'b0, 1'b0, 16'h0003, 16'h0, rd, me);
        chk(rd == 16'hBEEF, "R3 structure read data", {16'h0, rd}, 32'h0000_BEEF);

        // R4 R2: burst write words 8 and 9 (byte 16 -> offset 0x20)
        n0 = tx_cnt;
        access(1'b1, 1'b1, 1'b0, 16'h0008, 16'h1111, rd, me);
        chk(tx_cnt == n0, "R4 even word held without memory access", tx_cnt, n0);
        expect_tx(1'b1, 32'h0004_0020, 4'b1111, 32'h2222_1111, "R4 paired write");
        access(1'b1, 1'b1, 1'b1, 16'h0009, 16'h2222, rd, me);
        repeat (2) @(negedge clk);
        chk(tx_cnt == n0 + 1, "R4 one memory write per pair", tx_cnt, n0 + 1);

        // R7: burst read low then high half
        expect_tx(1'b0, 32'h0004_0020, 4'b1111, 32'h0, "R7 burst fetch");
        access(1'b0, 1'b1, 1'b0, 16'h0008, 16'h0, rd, me);
        chk(rd == 16'h1111, "R7 low half", {16'h0, rd}, 32'h1111);
        n0 = tx_cnt;
        access(1'b0, 1'b1, 1'b0, 16'h0009, 16'h0, rd, me);
        chk(rd == 16'h2222, "R7 high half from stored word", {16'h0, rd}, 32'h2222);
        chk(tx_cnt == n0, "R7 partner read makes no memory access", tx_cnt, n0);

        // R5: even word with last writes at once; R7 write discards stored word
        expect_tx(1'b1, 32'h0004_0020, 4'b0011, 32'h0000_3333, "R5 last even word");
        access(1'b1, 1'b1, 1'b1, 16'h0008, 16'h3333, rd, me);
        expect_tx(1'b0, 32'h0004_0020, 4'b1111, 32'h0, "R7 refetch after write");
        access(1'b0, 1'b1, 1'b0, 16'h0008, 16'h0, rd, me);
        chk(rd == 16'h3333, "R7 refetched data", {16'h0, rd}, 32'h3333);

        // R2 R5: odd word 5 alone (byte 10 -> offset 0x0A)
        expect_tx(1'b1, 32'h0004_0008, 4'b1100, 32'h5555_0000, "R5 unpaired odd word");
        access(1'b1, 1'b1, 1'b1, 16'h0005, 16'h5555, rd, me);

        // R6: held word 0x10 flushed before an unrelated read
        n0 = tx_cnt;
        access(1'b1, 1'b1, 1'b0, 16'h0010, 16'h7777, rd, me);
        chk(tx_cnt == n0, "R6 word held", tx_cnt, n0);
        expect_tx(1'b1, 32'h0004_0040, 4'b0011, 32'h0000_7777, "R6 flush of held word");
        expect_tx(1'b0, 32'h0004_000C, 4'b0011, 32'h0, "R6 read after flush");
        access(1'b0, 1'b0, 1'b0, 16'h0003, 16'h0, rd, me);
        chk(rd == 16'hBEEF, "R6 read data after flush", {16'h0, rd}, 32'hBEEF);

        // R8: out of window accesses
        n0 = tx_cnt;
        access(1'b0, 1'b0, 1'b0, 16'h8000, 16'h0, rd, me);
        chk(me == 1'b1, "R8 structure error pulse", {31'h0, me}, 32'h1);
        chk(rd == 16'h0, "R8 error read data zero", {16'h0, rd}, 32'h0);
        access(1'b1, 1'b1, 1'b1, 16'h8001, 16'h9999, rd, me);
        chk(me == 1'b1, "R8 buffer error pulse", {31'h0, me}, 32'h1);
        chk(tx_cnt == n0, "R8 no memory access on error", tx_cnt, n0);

        // R8 R2: last words inside the window
        expect_tx(1'b1, 32'h0005_FFEC, 4'b1100, 32'hABCD_0000, "R2 top buffer word");
        access(1'b1, 1'b1, 1'b1, 16'h7FFF, 16'hABCD, rd, me);
        chk(me == 1'b0, "R8 no error at buffer top", {31'h0, me}, 32'h0);
        expect_tx(1'b0, 32'h0005_FFFC, 4'b0011, 32'h0, "R3 top structure word");
        access(1'b0, 1'b0, 1'b0, 16'h7FFF, 16'h0, rd, me);
        chk(me == 1'b0, "R8 no error at structure top", {31'h0, me}, 32'h0);

        // R9: gating by the DMA enable
        n0 = tx_cnt;
        @(negedge clk);
        dma_en = 1'b0;
        expect_tx(1'b0, 32'h0004_000C, 4'b0011, 32'h0, "R9 read after enable");
        ctl_req = 1'b1; ctl_we = 1'b0; ctl_burst = 1'b0; ctl_last = 1'b0; ctl_addr = 16'h0003;
        me = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (ctl_ack) me = 1'b1;
        end
        chk(me == 1'b0 && tx_cnt == n0, "R9 no traffic while disabled", tx_cnt, n0);
        dma_en = 1'b1;
        do @(negedge clk); while (!ctl_ack);
        rd = ctl_rdata;
        ctl_req = 1'b0;
        chk(rd == 16'hBEEF, "R9 served after enable", {16'h0, rd}, 32'hBEEF);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R6 all expected memory accesses seen", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule